// File: doc/BRIEF.md
# Escaped Command Packet Receiver

This block sits behind a UART byte receiver and turns its byte stream into command packets. Bytes arrive on a valid/ready handshake. The receiver searches for an opening pair of bytes, then reads a length byte, a command byte, the payload and a checksum byte, and finally expects a two-byte closing pair. Any header, body or checksum byte equal to the escape value 04h reaches the wire as two copies of 04h. The receiver keeps only the second copy. Payload bytes are written into a local buffer. The consumer reads that buffer through an asynchronous read port.

When a frame closes correctly and its additive checksum works out, the receiver raises a one-cycle completion pulse. It presents the command byte and the payload count with that pulse. Broken frames leave no trace on the outputs: bad checksums, early closing pairs, unknown escape pairs and wrong trailers all have this effect. The receiver then returns to searching for the next opening pair.

Top module: `esc_frame_rx`

## Requirements
- R1: After a synchronous reset, frameDone is 0, inReady is 1, and frameCmd and frameCount are both 00h.
- R2: A frame opens with 02h immediately followed by 04h. A 02h that follows a 02h keeps the search waiting for 04h. Any other byte that follows 02h sends the search back to waiting for 02h. Bytes before an opening pair are ignored.
- R3: After the opening pair, the receiver takes bytes in this order: a length byte N, a command byte, N payload bytes and one checksum byte. Payload byte i is readable on rdData when rdAddr equals i. frameCount reports N.
- R4: Inside the length, command, payload and checksum fields, the pair 04h 04h stands for one data byte of value 04h. The first copy counts neither toward N nor toward the checksum.
- R5: A frame is accepted only if the 8-bit sum of the length, command, payload and checksum values, taken after de-escaping, is 00h. A rejected frame produces no frameDone and leaves frameCmd and frameCount unchanged.
- R6: If an unpaired 04h followed by 03h arrives before the checksum byte has been taken, the frame is aborted without frameDone.
- R7: Inside the fields, 04h followed by any byte other than 04h or 03h is a framing error, and the frame is dropped without frameDone.
- R8: After the checksum byte, the receiver requires exactly 04h then 03h. Any other byte there drops the frame. frameDone only ever follows an accepted 03h.
- R9: frameDone is high for exactly one cycle, in the cycle after the closing 03h is accepted. inReady is low in that cycle. frameCmd and frameCount hold their values until the next accepted frame.
- R10: A frame with N = 0 is accepted, and frameCount reports 0.
- R11: After any dropped frame, the next well-formed frame is received correctly.
- R12: Asserting rst in the middle of a frame abandons it and clears the running sum. The bytes that follow are treated as hunting input, and the next complete frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Byte on inData is offered |
| inData | input | 8 | Received byte |
| inReady | output | 1 | Receiver accepts a byte this cycle |
| rdAddr | input | 8 | Payload buffer read address |
| rdData | output | 8 | Payload byte at rdAddr |
| frameDone | output | 1 | One-cycle pulse for an accepted frame |
| frameCmd | output | 8 | Command byte of the last accepted frame |
| frameCount | output | 8 | Payload count of the last accepted frame |

## Verification
The checker verifies every cycle that the completion pulse lasts one cycle, that it stalls input, that it arrives only right after an accepted 03h, and that the reported command and count never move except with the pulse or a reset. Whether a given frame should have been accepted can only be shown by the bench's scenarios. This covers the checksum arithmetic, de-escaping, early closing pairs, unknown escape pairs, bad trailers, restarts of the search and reset in mid-frame. The bench also confirms the payload contents through the read port.

// File: rtl/esc_rx_pkg.sv
`timescale 1ns/1ps
package esc_rx_pkg;
  localparam logic [7:0] SOF_BYTE = 8'h02;
  localparam logic [7:0] ESC_BYTE = 8'h04;
  localparam logic [7:0] EOF_BYTE = 8'h03;

  typedef enum logic [3:0] {
    ST_HUNT,
    ST_OPEN,
    ST_LEN,
    ST_CMD,
    ST_PAY,
    ST_CHK,
    ST_TAILESC,
    ST_TAILEOF,
    ST_DONE
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFrame;
    logic takeLen;
    logic takeCmd;
    logic takePay;
    logic addSum;
    logic publish;
  } dpCtl_t;
endpackage

// File: rtl/esc_rx_ctrl.sv
`timescale 1ns/1ps
module esc_rx_ctrl
  import esc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       lenZero,
  input  logic       lenTooBig,
  input  logic       lastPay,
  input  logic       sumZero,
  output logic       inReady,
  output logic       frameDone,
  output dpCtl_t     ctl
);
  rxState_t state, stateNext;
  logic escPend, escNext;
  logic take, isEsc, dataOk;

  assign inReady   = (state != ST_DONE);
  assign frameDone = (state == ST_DONE);
  assign take      = inValid && inReady;
  assign isEsc     = (inData == ESC_BYTE);

  always_comb begin
    stateNext = state;
    escNext   = escPend;
    ctl       = '0;
    dataOk    = 1'b0;
    if (take) begin
      case (state)
        ST_HUNT: if (inData == SOF_BYTE) stateNext = ST_OPEN;
        ST_OPEN: begin
          if (isEsc) begin
            stateNext    = ST_LEN;
            ctl.clrFrame = 1'b1;
            escNext      = 1'b0;
          end else if (inData != SOF_BYTE) begin
            stateNext = ST_HUNT;
          end
        end
        ST_LEN, ST_CMD, ST_PAY, ST_CHK: begin
          if (escPend) begin
            escNext = 1'b0;
            // doubled escape is data; escape+anything else (incl. 03h) aborts
            if (isEsc) dataOk = 1'b1;
            else       stateNext = ST_HUNT;
          end else if (isEsc) begin
            escNext = 1'b1;
          end else begin
            dataOk = 1'b1;
          end
        end
        ST_TAILESC: stateNext = isEsc ? ST_TAILEOF : ST_HUNT;
        ST_TAILEOF: begin
          if (inData == EOF_BYTE && sumZero) begin
            stateNext   = ST_DONE;
            ctl.publish = 1'b1;
          end else begin
            stateNext = ST_HUNT;
          end
        end
        default: ;
      endcase
    end

    if (dataOk) begin
      ctl.addSum = 1'b1;
      case (state)
        ST_LEN: begin
          ctl.takeLen = 1'b1;
          stateNext   = lenTooBig ? ST_HUNT : ST_CMD;
        end
        ST_CMD: begin
          ctl.takeCmd = 1'b1;
          stateNext   = lenZero ? ST_CHK : ST_PAY;
        end
        ST_PAY: begin
          ctl.takePay = 1'b1;
          if (lastPay) stateNext = ST_CHK;
        end
        ST_CHK: stateNext = ST_TAILESC;
        default: ;
      endcase
    end

    if (state == ST_DONE) stateNext = ST_HUNT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      escPend <= 1'b0;
    end else begin
      state   <= stateNext;
      escPend <= escNext;
    end
  end
endmodule

// File: rtl/esc_rx_dp.sv
`timescale 1ns/1ps
module esc_rx_dp
  import esc_rx_pkg::*;
#(
  parameter  int MAX_PAYLOAD = 255,
  localparam int AW          = $clog2(MAX_PAYLOAD + 1),
  localparam int DEPTH       = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    inData,
  input  dpCtl_t        ctl,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          lenZero,
  output logic          lenTooBig,
  output logic          lastPay,
  output logic          sumZero,
  output logic [7:0]    frameCmd,
  output logic [7:0]    frameCount
);
  logic [7:0] lenReg, cmdReg, cntReg, sumReg;
  logic [7:0] payMem [DEPTH];

  assign lenZero   = (lenReg == 8'h00);
  assign lenTooBig = ({1'b0, inData} > 9'(MAX_PAYLOAD));
  assign lastPay   = ((cntReg + 8'd1) == lenReg);
  assign sumZero   = (sumReg == 8'h00);
  assign rdData    = payMem[rdAddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      lenReg     <= '0;
      cmdReg     <= '0;
      cntReg     <= '0;
      sumReg     <= '0;
      frameCmd   <= '0;
      frameCount <= '0;
    end else begin
      if (ctl.clrFrame) begin
        sumReg <= '0;
        cntReg <= '0;
      end
      if (ctl.addSum)  sumReg <= sumReg + inData;
      if (ctl.takeLen) lenReg <= inData;
      if (ctl.takeCmd) cmdReg <= inData;
      if (ctl.takePay) cntReg <= cntReg + 8'd1;
      if (ctl.publish) begin
        frameCmd   <= cmdReg;
        frameCount <= cntReg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.takePay) payMem[cntReg[AW-1:0]] <= inData;
  end
endmodule

// File: rtl/esc_frame_rx.sv
`timescale 1ns/1ps
module esc_frame_rx
  import esc_rx_pkg::*;
#(
  parameter  int MAX_PAYLOAD = 255,
  localparam int AW          = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic [7:0]    inData,
  output logic          inReady,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          frameDone,
  output logic [7:0]    frameCmd,
  output logic [7:0]    frameCount
);
  dpCtl_t ctl;
  logic lenZero, lenTooBig, lastPay, sumZero;

  esc_rx_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inData    (inData),
    .lenZero   (lenZero),
    .lenTooBig (lenTooBig),
    .lastPay   (lastPay),
    .sumZero   (sumZero),
    .inReady   (inReady),
    .frameDone (frameDone),
    .ctl       (ctl)
  );

  esc_rx_dp #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .inData     (inData),
    .ctl        (ctl),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .lenZero    (lenZero),
    .lenTooBig  (lenTooBig),
    .lastPay    (lastPay),
    .sumZero    (sumZero),
    .frameCmd   (frameCmd),
    .frameCount (frameCount)
  );
endmodule

// File: rtl/esc_frame_rx_chk.sv
`timescale 1ns/1ps
module esc_frame_rx_chk (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic [7:0] inData,
  input logic       inReady,
  input logic       frameDone,
  input logic [7:0] frameCmd,
  input logic [7:0] frameCount
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!frameDone && inReady && frameCmd == 8'h00 && frameCount == 8'h00));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone);

  assert_done_stall_R9: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> !inReady);

  assert_done_after_eof_R8: assert property (@(posedge clk) disable iff (rst)
    frameDone |-> $past(inValid && inReady && inData == 8'h03));

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!frameDone && !$past(rst)) |-> ($stable(frameCmd) && $stable(frameCount)));
endmodule

bind esc_frame_rx esc_frame_rx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .inData     (inData),
  .inReady    (inReady),
  .frameDone  (frameDone),
  .frameCmd   (frameCmd),
  .frameCount (frameCount)
);

// File: tb/esc_frame_rx_tb.sv
`timescale 1ns/1ps
module esc_frame_rx_tb;
  localparam int MAX_PAYLOAD = 255;
  localparam int AW = $clog2(MAX_PAYLOAD + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inReady;
  logic [AW-1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic frameDone;
  logic [7:0] frameCmd, frameCount;

  int nCompared = 0;
  int nMismatched = 0;

  typedef struct packed { logic [7:0] cmd; logic [7:0] cnt; } expFrame_t;
  expFrame_t expQ[$];
  logic [7:0] expPay [256];
  logic [7:0] stream[$];
  logic prevDone = 1'b0;

  always #5 clk = ~clk;

  esc_frame_rx #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData), .inReady(inReady),
    .rdAddr(rdAddr), .rdData(rdData), .frameDone(frameDone),
    .frameCmd(frameCmd), .frameCount(frameCount)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    while (!inReady) begin
      inValid = 1'b0;
      @(negedge clk);
    end
    inValid = 1'b1;
    inData  = b;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pushBody(input logic [7:0] b);
    if (b == 8'h04) stream.push_back(8'h04);
    stream.push_back(b);
  endtask

  // driver side of the scoreboard: builds a frame and queues its expectation
  task automatic buildFrame(input logic [7:0] cmd, input int n, input logic [7:0] seed,
                            input logic [7:0] sumErr, input bit expectIt);
    logic [7:0] sum;
    logic [7:0] b;
    stream.delete();
    stream.push_back(8'h02);
    stream.push_back(8'h04);
    sum = n[7:0] + cmd;
    pushBody(n[7:0]);
    pushBody(cmd);
    for (int i = 0; i < n; i++) begin
      b = seed + 8'(i * 3);
      expPay[i] = b;
      sum = sum + b;
      pushBody(b);
    end
    pushBody(8'h00 - sum + sumErr);
    stream.push_back(8'h04);
    stream.push_back(8'h03);
    if (expectIt) expQ.push_back('{cmd: cmd, cnt: n[7:0]});
  endtask

  task automatic sendStream();
    foreach (stream[i]) sendByte(stream[i]);
  endtask

  task automatic checkPayload(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      rdAddr = AW'(i);
      #1;
      check(req, "payload byte", rdData, expPay[i]);
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    expFrame_t e;
    if (rst) begin
      prevDone = 1'b0;
    end else begin
      if (frameDone) begin
        check("R9", "inReady while done", inReady, 1'b0);
        if (prevDone) check("R9", "done pulse width", 2, 1);
        if (expQ.size() == 0) begin
          check("R5", "unexpected frameDone", 1, 0);
        end else begin
          e = expQ.pop_front();
          check("R3", "frameCmd", frameCmd, e.cmd);
          check("R3", "frameCount", frameCount, e.cnt);
        end
      end
      prevDone = frameDone;
    end
  end

  initial begin
    #1_500_000;
    check("WATCHDOG", "run finished", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "frameDone", frameDone, 1'b0);
    check("R1", "inReady", inReady, 1'b1);
    check("R1", "frameCmd", frameCmd, 8'h00);
    check("R1", "frameCount", frameCount, 8'h00);

    // R3 basic frame
    buildFrame(8'h21, 5, 8'h10, 8'h00, 1);
    sendStream(); idle(3);
    check("R3", "basic frame reported", expQ.size(), 0);
    checkPayload(5, "R3");

    // R4 escaped length, command and payload
    buildFrame(8'h04, 4, 8'h01, 8'h00, 1);
    sendStream(); idle(3);
    check("R4", "escaped frame reported", expQ.size(), 0);
    checkPayload(4, "R4");

    // R4 checksum byte itself escaped (1+7B+80 = FC, checksum 04h)
    buildFrame(8'h7B, 1, 8'h80, 8'h00, 1);
    sendStream(); idle(3);
    check("R4", "escaped checksum frame", frameCmd, 8'h7B);

    // R10 zero-length frame
    buildFrame(8'h3C, 0, 8'h00, 8'h00, 1);
    sendStream(); idle(3);
    check("R10", "zero length count", frameCount, 8'h00);

    // R5 bad checksum
    buildFrame(8'h55, 3, 8'h20, 8'h01, 0);
    sendStream(); idle(3);
    check("R5", "cmd kept after bad sum", frameCmd, 8'h3C);

    // R6 premature closing pair
    stream = '{8'h02, 8'h04, 8'h05, 8'h66, 8'h10, 8'h11, 8'h04, 8'h03};
    sendStream(); idle(3);
    check("R6", "cmd kept after early end", frameCmd, 8'h3C);
    // R11 recovery
    buildFrame(8'h70, 2, 8'h30, 8'h00, 1);
    sendStream(); idle(3);
    check("R11", "recovered frame cmd", frameCmd, 8'h70);
    checkPayload(2, "R11");

    // R7 unknown escape pair
    stream = '{8'h02, 8'h04, 8'h02, 8'h77, 8'h04, 8'h55, 8'h33, 8'h04, 8'h03};
    sendStream(); idle(3);
    check("R7", "cmd kept after bad escape", frameCmd, 8'h70);
    buildFrame(8'h71, 6, 8'h40, 8'h00, 1);
    sendStream(); idle(3);
    check("R11", "frame after bad escape", frameCmd, 8'h71);

    // R8 wrong trailer
    buildFrame(8'h44, 2, 8'h50, 8'h00, 0);
    void'(stream.pop_back());
    stream.push_back(8'h05);
    sendStream(); idle(3);
    check("R8", "cmd kept after bad trailer", frameCmd, 8'h71);
    buildFrame(8'h45, 1, 8'h60, 8'h00, 0);
    void'(stream.pop_back());
    void'(stream.pop_back());
    stream.push_back(8'h03);
    sendStream(); idle(3);
    check("R8", "cmd kept after missing escape", frameCmd, 8'h71);

    // R2 hunting with junk and repeated 02h
    sendByte(8'h55); sendByte(8'h02); sendByte(8'h33); sendByte(8'h04); sendByte(8'h02);
    buildFrame(8'h5A, 3, 8'h70, 8'h00, 1);
    sendStream(); idle(3);
    check("R2", "frame after junk", frameCmd, 8'h5A);

    // R12 reset in mid-frame
    stream = '{8'h02, 8'h04, 8'h03, 8'h19, 8'hA0};
    sendStream();
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R12", "cmd cleared by reset", frameCmd, 8'h00);
    stream = '{8'hA1, 8'hA2, 8'h42, 8'h04, 8'h03};
    sendStream(); idle(3);
    check("R12", "tail after reset ignored", frameCmd, 8'h00);
    buildFrame(8'h6E, 2, 8'h90, 8'h00, 1);
    sendStream(); idle(3);
    check("R12", "frame after reset", frameCmd, 8'h6E);

    // R3 largest payload
    buildFrame(8'h99, 255, 8'h00, 8'h00, 1);
    sendStream(); idle(3);
    check("R3", "max count", frameCount, 8'd255);
    checkPayload(255, "R3");

    idle(5);
    check("R9", "all expected frames reported", expQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end
endmodule